// File: doc/BRIEF.md
# I2C Master Word Transfer Engine

This block is the data stage of an I2C bus master run by software. Software opens a transfer with a start command. It then moves one word at a time over the bus. It closes the transfer with a stop command. The serial clock comes from a programmable divider of the system clock. One half-period of SCL lasts `half_per_i + 1` system clocks. Data moves most significant bit first. The word length is chosen by a 3-bit code. An optional extra clock carries the acknowledge bit.

A word starts when software writes the data buffer, or when it raises the set-pending input in receive mode. The pending flag goes high while the word is on the bus. When the word ends, the pending flag clears and a one-cycle interrupt pulse is raised. The engine then holds SCL low until software issues its next command. In transmit mode the bit seen on SDA during the acknowledge clock is kept as the last received bit. A value of 1 there tells software to send a stop. In receive mode the master drives the acknowledge itself. After a receive word, software reads the word from the data buffer. The first word read after the address byte is a dummy read.

SDA and SCL are open-drain. `sda_oe_o` = 1 pulls SDA low, and 0 releases it to the bus pull-up. `scl_o` is the level the master puts on SCL.

Top module: `i2c_word_master`

## Requirements
- R1: After reset, scl_o = 1, sda_oe_o = 0, pin_o = 0, mst_o = 0, irq_o = 0, lrb_o = 0, trx_o = 0 and rd_data_o = 0x00.
- R2: A start_i pulse while mst_o = 0 pulls SDA low with SCL high for one half-period. SCL then goes low and stays low with SDA low, and mst_o = 1 from the cycle after the pulse. start_i has no effect while mst_o = 1.
- R3: While the engine is holding SCL low between words (mst_o = 1, pin_o = 0), a wr_i pulse loads wr_data_i into the buffer. In the next cycle pin_o = 1, trx_o takes the value of tx_mode_i, and the word begins.
- R4: Each bit takes one SCL low half-period and then one high half-period, each `half_per_i + 1` clocks long. SDA changes only while SCL is low. In transmit mode the bits go out MSB first from buffer bit 7 downward, with sda_oe_o = 1 for a 0 and sda_oe_o = 0 for a 1.
- R5: bit_code_i = 0 selects an 8-bit word. A code N from 1 to 7 selects an N-bit word. The code is captured when the word starts.
- R6: With ack_en_i = 1 at word start, a further clock follows the data bits. In transmit mode SDA is released during that clock, and the line level at the end of its high half is stored in lrb_o.
- R7: In receive mode (trx_o = 0), SDA stays released during the data bits. The line is sampled in the last cycle of each high half and shifted into rd_data_o bit 0, moving older bits left, so an N-bit word ends in rd_data_o[N-1:0]. With acknowledge enabled, the master holds SDA low during the acknowledge clock. A set_pin_i pulse with tx_mode_i = 0 starts a receive word without loading the buffer.
- R8: When a word ends, pin_o returns to 0 and irq_o is high for exactly one cycle. SCL and SDA are then both held low until the next accepted command.
- R9: wr_i, set_pin_i, start_i and stop_i have no effect while a word, a start or a stop is in progress.
- R10: A stop_i pulse is taken only while SCL is being held low between words. SCL stays low for one half-period with SDA low, then rises for one half-period with SDA still low. SDA is then released and mst_o falls.
- R11: When several commands arrive in the same holding cycle, wr_i wins over set_pin_i, and set_pin_i (with tx_mode_i = 0) wins over stop_i. set_pin_i with tx_mode_i = 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_per_i | input | DIV_W | SCL half-period minus one, in system clocks |
| bit_code_i | input | CW | Word length code (0 = W bits) |
| ack_en_i | input | 1 | Add an acknowledge clock after the word |
| tx_mode_i | input | 1 | Direction for the next word (1 = transmit) |
| start_i | input | 1 | Start condition command |
| stop_i | input | 1 | Stop condition command |
| wr_i | input | 1 | Write strobe for the data buffer |
| wr_data_i | input | W | Data written to the buffer |
| set_pin_i | input | 1 | Start a receive word without a buffer write |
| rd_data_o | output | W | Data buffer contents |
| pin_o | output | 1 | Word in progress |
| lrb_o | output | 1 | Last acknowledge bit seen in transmit mode |
| mst_o | output | 1 | Bus owned by this master |
| trx_o | output | 1 | Direction of the current or last word |
| irq_o | output | 1 | One-cycle end-of-word pulse |
| scl_o | output | 1 | SCL level driven by the master |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The SDA-stability and pending-flag assertions assume that half_per_i stays constant while a phase is running. They also assume that sda_i is the wired level of the bus, so it can only be low while the engine or the slave pulls it. The bench keeps to this. It changes the divider setting only between transfers, after the stop. It builds sda_i from the engine's own enable together with a slave that updates its drive on the falling system clock. Commands are always one-cycle pulses driven on the falling edge. Some of them are deliberately placed in the middle of words and in the same cycle as other commands.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_LOW, ST_HIGH, ST_STOP_A, ST_STOP_B
  } st_e;
endpackage

// File: rtl/i2cw_div.sv
module i2cw_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == half_i);

  // restarts at every phase boundary so each half-period is exact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cw_shift.sv
module i2cw_shift #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [CW-1:0] code_i,
  input  logic          load_i,
  input  logic [W-1:0]  data_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [W-1:0]  data_o,
  output logic          msb_o,
  output logic          last_o
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;

  assign data_o = sh_q;
  assign msb_o  = sh_q[W-1];
  assign last_o = (left_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      if (load_i)       sh_q <= data_i;
      else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
      if (arm_i)        left_q <= (code_i == '0) ? LW'(W) : LW'(code_i);
      else if (shift_i) left_q <= left_q - 1'b1;
    end
  end

  p_left_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= LW'(W));
  p_shift_counts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !arm_i) |=> left_q == $past(left_q) - 1'b1);
endmodule

// File: rtl/i2c_word_master.sv
module i2c_word_master #(
  parameter  int W     = 8,
  parameter  int DIV_W = 8,
  localparam int CW    = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] half_per_i,
  input  logic [CW-1:0]    bit_code_i,
  input  logic             ack_en_i,
  input  logic             tx_mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             set_pin_i,
  output logic [W-1:0]     rd_data_o,
  output logic             pin_o,
  output logic             lrb_o,
  output logic             mst_o,
  output logic             trx_o,
  output logic             irq_o,
  output logic             scl_o,
  output logic             sda_oe_o,
  input  logic             sda_i
);
  import i2cw_pkg::*;

  st_e  st;
  logic pin_q, mst_q, trx_q, lrb_q, irq_q, ack_q, ack_ph;
  logic tick, div_en, hold, go_wr, go_rx, go_word, go_stop;
  logic shift, last, msb, bit_oe;

  assign hold    = (st == ST_HOLD);
  assign go_wr   = hold && wr_i;
  assign go_rx   = hold && !wr_i && set_pin_i && !tx_mode_i;
  assign go_word = go_wr || go_rx;
  assign go_stop = hold && stop_i && !go_word;
  assign div_en  = (st == ST_START) || (st == ST_LOW) || (st == ST_HIGH) ||
                   (st == ST_STOP_A) || (st == ST_STOP_B);
  assign shift   = (st == ST_HIGH) && tick && !ack_ph;

  i2cw_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (div_en),
    .half_i(half_per_i), .tick_o (tick)
  );

  i2cw_shift #(.W(W), .CW(CW)) u_shift (
    .clk_i  (clk_i),   .rst_ni (rst_ni),
    .arm_i  (go_word), .code_i (bit_code_i),
    .load_i (go_wr),   .data_i (wr_data_i),
    .shift_i(shift),   .bit_i  (sda_i),
    .data_o (rd_data_o), .msb_o (msb), .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_IDLE;
      pin_q  <= 1'b0;
      mst_q  <= 1'b0;
      trx_q  <= 1'b0;
      lrb_q  <= 1'b0;
      irq_q  <= 1'b0;
      ack_q  <= 1'b0;
      ack_ph <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          st    <= ST_START;
          mst_q <= 1'b1;
        end
        ST_START: if (tick) st <= ST_HOLD;
        ST_HOLD: begin
          if (go_word) begin
            st     <= ST_LOW;
            pin_q  <= 1'b1;
            trx_q  <= tx_mode_i;
            ack_q  <= ack_en_i;
            ack_ph <= 1'b0;
          end else if (go_stop) begin
            st <= ST_STOP_A;
          end
        end
        ST_LOW: if (tick) st <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (ack_ph) begin
            if (trx_q) lrb_q <= sda_i;
            st    <= ST_HOLD;
            pin_q <= 1'b0;
            irq_q <= 1'b1;
          end else if (!last) begin
            st <= ST_LOW;
          end else if (ack_q) begin
            ack_ph <= 1'b1;
            st     <= ST_LOW;
          end else begin
            st    <= ST_HOLD;
            pin_q <= 1'b0;
            irq_q <= 1'b1;
          end
        end
        ST_STOP_A: if (tick) st <= ST_STOP_B;
        ST_STOP_B: if (tick) begin
          st    <= ST_IDLE;
          mst_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // transmitter releases on the ack clock, receiver pulls low to acknowledge
  assign bit_oe = ack_ph ? !trx_q : (trx_q && !msb);

  always_comb begin
    scl_o    = 1'b1;
    sda_oe_o = 1'b0;
    unique case (st)
      ST_IDLE:   ;
      ST_START:  sda_oe_o = 1'b1;
      ST_HOLD:   begin scl_o = 1'b0; sda_oe_o = 1'b1; end
      ST_LOW:    begin scl_o = 1'b0; sda_oe_o = bit_oe; end
      ST_HIGH:   sda_oe_o = bit_oe;
      ST_STOP_A: begin scl_o = 1'b0; sda_oe_o = 1'b1; end
      ST_STOP_B: sda_oe_o = 1'b1;
      default:   ;
    endcase
  end

  assign pin_o = pin_q;
  assign mst_o = mst_q;
  assign trx_o = trx_q;
  assign lrb_o = lrb_q;
  assign irq_o = irq_q;

  p_sda_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && mst_o && $past(mst_o)) |-> $stable(sda_oe_o));
  p_pin_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_o) |-> $past(wr_i || set_pin_i));
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!pin_o && !scl_o && sda_oe_o && mst_o));
  p_stop_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mst_o) |-> (scl_o && !sda_oe_o && !pin_o));
  p_start_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_o) |-> $past(start_i));
endmodule

// File: tb/i2c_word_master_tb.sv
`timescale 1ns/1ps
module i2c_word_master_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] half_per_i = 8'd2;
  logic [2:0] bit_code_i = '0;
  logic       ack_en_i = 1'b0, tx_mode_i = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, wr_i = 1'b0, set_pin_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       pin_o, lrb_o, mst_o, trx_o, irq_o, scl_o, sda_oe_o, sda_i;
  logic       slave_low = 1'b0;

  always #4 clk = ~clk;

  assign sda_i = !sda_oe_o && !slave_low;

  i2c_word_master u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_per_i(half_per_i),
    .bit_code_i(bit_code_i), .ack_en_i(ack_en_i), .tx_mode_i(tx_mode_i),
    .start_i(start_i), .stop_i(stop_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .set_pin_i(set_pin_i), .rd_data_o(rd_data_o), .pin_o(pin_o),
    .lrb_o(lrb_o), .mst_o(mst_o), .trx_o(trx_o), .irq_o(irq_o),
    .scl_o(scl_o), .sda_oe_o(sda_oe_o), .sda_i(sda_i)
  );

  int checks = 0, fails = 0, cyc = 0, irq_seen = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // ---------------- reference model: per-cycle schedule queue ----------------
  typedef struct packed {
    logic       scl;
    logic       oe;
    logic       sl;
    logic [3:0] act;   // 0 shift-in, 1 store lrb, 2 word done, 3 stop done
  } rec_t;

  rec_t       q[$];
  rec_t       cur = '{scl: 1'b1, oe: 1'b0, sl: 1'b0, act: 4'd0};
  bit         m_busy = 0;
  logic       m_mst = 0, m_pin = 0, m_trx = 0, m_lrb = 0, m_irq = 0, m_line;
  logic [7:0] m_buf = '0;
  logic [7:0] rx_pat = '0;
  logic       ack_bit = 1'b0;

  function automatic void push(logic scl, logic oe, logic sl, int len, logic [3:0] a);
    for (int k = 0; k < len; k++)
      q.push_back('{scl: scl, oe: oe, sl: sl, act: (k == len - 1) ? a : 4'd0});
  endfunction

  function automatic void push_word(logic tx, logic [7:0] d, logic [2:0] code,
                                    logic ack, int h);
    int  n = (code == 0) ? 8 : int'(code);
    logic oe, sl;
    for (int i = 0; i < n; i++) begin
      oe = tx ? !d[7-i] : 1'b0;
      sl = tx ? 1'b0 : !rx_pat[7-i];
      push(1'b0, oe, sl, h + 1, 4'd0);
      push(1'b1, oe, sl, h + 1, ((i == n - 1) && !ack) ? 4'b0101 : 4'b0001);
    end
    if (ack) begin
      oe = !tx;
      sl = tx ? !ack_bit : 1'b0;
      push(1'b0, oe, sl, h + 1, 4'd0);
      push(1'b1, oe, sl, h + 1, tx ? 4'b0110 : 4'b0100);
    end
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      cur = '{scl: 1'b1, oe: 1'b0, sl: 1'b0, act: 4'd0};
      m_busy = 0; m_mst = 0; m_pin = 0; m_trx = 0; m_lrb = 0; m_irq = 0;
      m_buf = '0;
    end else begin
      m_line = !cur.oe && !slave_low;
      m_irq  = 0;
      if (m_busy) begin
        if (cur.act[0]) m_buf = {m_buf[6:0], m_line};
        if (cur.act[1]) m_lrb = m_line;
        if (cur.act[2]) begin m_pin = 0; m_irq = 1; end
        if (cur.act[3]) m_mst = 0;
      end else if (!m_mst) begin
        if (start_i) begin
          m_mst = 1;
          push(1'b1, 1'b1, 1'b0, int'(half_per_i) + 1, 4'd0);
        end
      end else if (wr_i) begin
        m_buf = wr_data_i; m_pin = 1; m_trx = tx_mode_i;
        push_word(tx_mode_i, wr_data_i, bit_code_i, ack_en_i, int'(half_per_i));
      end else if (set_pin_i && !tx_mode_i) begin
        m_pin = 1; m_trx = 0;
        push_word(1'b0, m_buf, bit_code_i, ack_en_i, int'(half_per_i));
      end else if (stop_i) begin
        push(1'b0, 1'b1, 1'b0, int'(half_per_i) + 1, 4'd0);
        push(1'b1, 1'b1, 1'b0, int'(half_per_i) + 1, 4'b1000);
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        m_busy = 1;
      end else begin
        m_busy = 0;
        if (m_mst) cur = '{scl: 1'b0, oe: 1'b1, sl: 1'b0, act: 4'd0};
        else       cur = '{scl: 1'b1, oe: 1'b0, sl: 1'b0, act: 4'd0};
      end
    end
  end

  always @(negedge clk) slave_low <= cur.sl;

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk("R4", "scl_o", scl_o, cur.scl);
      chk("R4", "sda_oe_o", sda_oe_o, cur.oe);
      chk("R3", "pin_o", pin_o, m_pin);
      chk("R2", "mst_o", mst_o, m_mst);
      chk("R8", "irq_o", irq_o, m_irq);
      chk("R6", "lrb_o", lrb_o, m_lrb);
      chk("R3", "trx_o", trx_o, m_trx);
      chk("R7", "rd_data_o", rd_data_o, m_buf);
      if (irq_o) irq_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog all act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic settle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    settle();
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    settle();
  endtask

  task automatic send(logic tx, logic [7:0] d, logic [2:0] code, logic ack);
    @(negedge clk);
    wr_i = 1; wr_data_i = d; tx_mode_i = tx; bit_code_i = code; ack_en_i = ack;
    @(negedge clk); wr_i = 0;
    settle();
  endtask

  task automatic recv_pin(logic [2:0] code, logic ack);
    @(negedge clk);
    set_pin_i = 1; tx_mode_i = 0; bit_code_i = code; ack_en_i = ack;
    @(negedge clk); set_pin_i = 0;
    settle();
  endtask

  int words = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "scl_o", scl_o, 1);
    chk("R1", "sda_oe_o", sda_oe_o, 0);
    chk("R1", "pin_o", pin_o, 0);
    chk("R1", "mst_o", mst_o, 0);
    chk("R1", "irq_o", irq_o, 0);
    chk("R1", "rd_data_o", rd_data_o, 0);
    rst_ni = 1;

    do_start();
    chk("R2", "mst after start", mst_o, 1);
    chk("R2", "scl held low", scl_o, 0);

    ack_bit = 0;
    send(1, 8'hA5, 3'd0, 1); words++;
    chk("R6", "lrb ack", lrb_o, 0);

    ack_bit = 1;
    send(1, 8'h3C, 3'd0, 1); words++;
    chk("R6", "lrb nack", lrb_o, 1);

    // commands during a word are ignored (R9)
    ack_bit = 0;
    @(negedge clk);
    wr_i = 1; wr_data_i = 8'h6E; tx_mode_i = 1; bit_code_i = 0; ack_en_i = 1;
    @(negedge clk); wr_i = 0;
    repeat (5) @(negedge clk);
    wr_i = 1; wr_data_i = 8'hFF; stop_i = 1; start_i = 1; set_pin_i = 1;
    @(negedge clk); wr_i = 0; stop_i = 0; start_i = 0; set_pin_i = 0;
    settle(); words++;
    chk("R9", "mst kept", mst_o, 1);
    chk("R9", "buffer kept", rd_data_o, 8'h6E);

    repeat (10) @(negedge clk);
    chk("R8", "scl held low", scl_o, 0);
    chk("R8", "pin clear", pin_o, 0);

    // receive via dummy write, 8 bits with master ack
    rx_pat = 8'h96;
    send(0, 8'h00, 3'd0, 1); words++;
    chk("R7", "rx dummy write", rd_data_o, 8'h96);

    // receive via set_pin, no ack
    rx_pat = 8'h5B;
    recv_pin(3'd0, 0); words++;
    chk("R7", "rx set_pin", rd_data_o, 8'h5B);

    // short words
    ack_bit = 0;
    send(1, 8'hE0, 3'd3, 1); words++;
    chk("R5", "3-bit tx lrb", lrb_o, 0);
    rx_pat = 8'hA0;
    recv_pin(3'd3, 1); words++;
    chk("R5", "3-bit rx", rd_data_o[2:0], 3'b101);
    rx_pat = 8'h40;
    recv_pin(3'd1, 0); words++;
    chk("R5", "1-bit rx", rd_data_o[0], 0);

    // priority: write beats set_pin and stop
    rx_pat = 8'h00;
    @(negedge clk);
    wr_i = 1; set_pin_i = 1; stop_i = 1; wr_data_i = 8'hC3; tx_mode_i = 1;
    bit_code_i = 0; ack_en_i = 0;
    @(negedge clk); wr_i = 0; set_pin_i = 0; stop_i = 0;
    chk("R11", "write wins pin", pin_o, 1);
    chk("R11", "write wins trx", trx_o, 1);
    settle(); words++;

    // set_pin beats stop in receive mode
    rx_pat = 8'h71;
    @(negedge clk);
    set_pin_i = 1; stop_i = 1; tx_mode_i = 0; bit_code_i = 0; ack_en_i = 1;
    @(negedge clk); set_pin_i = 0; stop_i = 0;
    chk("R11", "set_pin wins pin", pin_o, 1);
    chk("R11", "set_pin wins trx", trx_o, 0);
    settle(); words++;
    chk("R7", "rx after priority", rd_data_o, 8'h71);

    // set_pin in transmit mode ignored; stop taken
    @(negedge clk);
    set_pin_i = 1; stop_i = 1; tx_mode_i = 1;
    @(negedge clk); set_pin_i = 0; stop_i = 0;
    chk("R11", "tx set_pin ignored", pin_o, 0);
    settle();
    chk("R10", "mst after stop", mst_o, 0);
    chk("R10", "scl released", scl_o, 1);
    chk("R10", "sda released", sda_oe_o, 0);

    // idle: word commands ignored
    @(negedge clk); wr_i = 1; wr_data_i = 8'h11;
    @(negedge clk); wr_i = 0;
    repeat (4) @(negedge clk);
    chk("R9", "idle write pin", pin_o, 0);

    // fastest divider
    @(negedge clk); half_per_i = 8'd0;
    do_start();
    chk("R2", "restart mst", mst_o, 1);
    ack_bit = 1;
    send(1, 8'h81, 3'd0, 1); words++;
    chk("R6", "fast nack", lrb_o, 1);
    do_stop();
    chk("R10", "fast stop", mst_o, 0);

    chk("R8", "irq pulse count", irq_seen, words);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule